// File: doc/BRIEF.md
# Per-Slave Bus Arbiter with Burst Slot Limit and Idle Parking

This block decides which of up to eight bus masters owns one slave port of a multi-master interconnect. Every cycle it looks at each master's request, its burst-in-progress flag and a mask saying which masters can reach this slave at all. From these it drives a one-hot grant vector, the index of the owning master and a flag telling whether any master owns the port. The grant is registered. A master that is not already connected sees its grant one cycle after it raises its request. A master that is already parked on the slave is served in the same cycle.

A 32-bit configuration word sets the policy. It chooses round-robin or fixed-priority selection. It holds a slot limit that lets a long burst be cut so other masters can get in. It also picks what happens when nobody is requesting: the port can drop all grants, stay with the last owner, or move to a chosen master. Parking removes the arbitration cycle for the parked master's next access. All pins are plain level signals sampled on the rising clock. There is no stream payload, so no valid/ready handshake or back-pressure applies.

Top module: `slave_arbiter`

## Requirements
- R1: While reset is held and on the first cycle after it, `grant` is all zero, `owner_valid` is 0 and `owner_idx` is N-1 (7), so the first round-robin search starts at master 0.
- R2: `grant` is one-hot or zero. A master that is not owner or parked gets its grant on the clock edge after its request is seen, and not before.
- R3: With arbitration type (cfg bits 25:24) equal to 1, the lowest-index master that is requesting and attached wins each arbitration.
- R4: With arbitration type 0, and also with the reserved values 2 and 3, the search is round-robin. It starts at the master after the last owner and wraps past N-1 to 0.
- R5: An owner that keeps its request and burst flag high keeps the grant whatever others request, until the slot limit ends the slot. A slot limit (cfg bits 7:0) of 0 never ends a slot.
- R6: With a slot limit L>0, an owner in a burst holds the grant for L requesting cycles. On the next edge the grant moves to another requesting master, if one exists. With no competitor, the owner keeps the grant.
- R7: With idle policy (cfg bits 17:16) 0, or the reserved value 3, the grant drops to none on the edge after no attached master requests.
- R8: With idle policy 1, the last owner keeps its grant while nobody requests. A new request from it finds the grant already high in the same cycle.
- R9: With idle policy 2, an idle port moves to the master numbered in cfg bits 20:18. If that master is not attached or does not exist, the port behaves as with policy 0.
- R10: A master whose attach bit is 0 is never granted. Its request has no effect on the grant.
- R11: When the owner still requests but its burst flag is low (an access boundary), arbitration runs again with the owner included among the candidates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mst_req | input | N_MASTERS | Per-master access request to this slave |
| mst_burst | input | N_MASTERS | Per-master flag: a burst is in progress and continues |
| mst_attached | input | N_MASTERS | Per-master mask: master can reach this slave |
| cfg_word | input | 32 | Slot limit [7:0], idle policy [17:16], parking master [20:18], arbitration type [25:24]; other bits unused |
| grant | output | N_MASTERS | One-hot grant, zero when the port is unowned |
| owner_idx | output | IDX_W | Index of the current or most recent owner |
| owner_valid | output | 1 | A master currently owns the port |

## Verification
The arbiter has three pieces of state: the owner register, its valid flag and the slot counter. Each one shows up at the ports quickly. A wrong owner index first shows as a round-robin winner that is out of order, at the very next arbitration. It can also show as the wrong master being parked or held. A slot counter that is off by one moves the grant one cycle early or late, within L+1 cycles of a contested burst starting. Parking faults show on the first idle cycle as a grant that is present when it should be absent, or the reverse. The directed scenarios therefore check the grant vector on every cycle around each switch point.

// File: rtl/arb_pkg.sv
package arb_pkg;

  localparam int CFG_W  = 32;
  localparam int SLOT_W = 8;
  localparam int FIX_W  = 3;

  localparam int SLOT_LSB = 0;
  localparam int PARK_LSB = 16;
  localparam int FIX_LSB  = 18;
  localparam int MODE_LSB = 24;

  typedef enum logic [1:0] {
    PARK_NONE  = 2'd0,
    PARK_LAST  = 2'd1,
    PARK_FIXED = 2'd2
  } park_e;

  typedef struct packed {
    logic [SLOT_W-1:0] slot_limit;
    park_e             park;
    logic [FIX_W-1:0]  park_idx;
    logic              use_rr;
  } arb_cfg_t;

endpackage

// File: rtl/arb_cfg_decode.sv
module arb_cfg_decode
  import arb_pkg::*;
(
  input  logic [CFG_W-1:0] cfg_word,
  output arb_cfg_t         cfg
);

  logic [1:0] park_raw;
  logic [1:0] mode_raw;
  logic       unused_cfg_bits;

  assign park_raw = cfg_word[PARK_LSB +: 2];
  assign mode_raw = cfg_word[MODE_LSB +: 2];

  always_comb begin
    cfg.slot_limit = cfg_word[SLOT_LSB +: SLOT_W];
    cfg.park_idx   = cfg_word[FIX_LSB +: FIX_W];
    // reserved idle policy 3 folds into "no parking"
    unique case (park_raw)
      2'd1:    cfg.park = PARK_LAST;
      2'd2:    cfg.park = PARK_FIXED;
      default: cfg.park = PARK_NONE;
    endcase
    // only value 1 selects fixed priority; reserved values fall back to round-robin
    cfg.use_rr = (mode_raw != 2'd1);
  end

  assign unused_cfg_bits = ^{cfg_word[31:26], cfg_word[23:21], cfg_word[15:8]};

endmodule

// File: rtl/arb_pick.sv
module arb_pick #(
  parameter int N_MASTERS = 8,
  localparam int IDX_W = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic [N_MASTERS-1:0] cand,
  input  logic [IDX_W-1:0]     last_idx,
  input  logic                 use_rr,
  output logic                 found,
  output logic [IDX_W-1:0]     pick_idx
);

  logic             rr_found;
  logic [IDX_W-1:0] rr_idx;
  logic             fp_found;
  logic [IDX_W-1:0] fp_idx;

  // round-robin: first candidate after the last owner, wrapping
  always_comb begin
    rr_found = 1'b0;
    rr_idx   = '0;
    for (int k = 0; k < N_MASTERS; k++) begin
      int pos;
      pos = (int'(last_idx) + 1 + k) % N_MASTERS;
      if (!rr_found && cand[pos]) begin
        rr_found = 1'b1;
        rr_idx   = IDX_W'(pos);
      end
    end
  end

  // fixed priority: lowest index wins
  always_comb begin
    fp_found = 1'b0;
    fp_idx   = '0;
    for (int i = N_MASTERS - 1; i >= 0; i--) begin
      if (cand[i]) begin
        fp_found = 1'b1;
        fp_idx   = IDX_W'(i);
      end
    end
  end

  assign found    = use_rr ? rr_found : fp_found;
  assign pick_idx = use_rr ? rr_idx   : fp_idx;

endmodule

// File: rtl/arb_slot_timer.sv
module arb_slot_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);

  logic [CNT_W-1:0] held_q;

  // held_q = requesting cycles already spent by the owner before this one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      held_q <= '0;
    else if (!advance)
      held_q <= '0;
    else if (held_q != {CNT_W{1'b1}})
      held_q <= held_q + 1'b1;
  end

  assign expired = (limit != '0) && (held_q >= limit - 1'b1);

endmodule

// File: rtl/slave_arbiter.sv
module slave_arbiter
  import arb_pkg::*;
#(
  parameter int N_MASTERS = 8,
  localparam int IDX_W = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MASTERS-1:0] mst_req,
  input  logic [N_MASTERS-1:0] mst_burst,
  input  logic [N_MASTERS-1:0] mst_attached,
  input  logic [CFG_W-1:0]     cfg_word,
  output logic [N_MASTERS-1:0] grant,
  output logic [IDX_W-1:0]     owner_idx,
  output logic                 owner_valid
);

  arb_cfg_t cfg;

  logic                 valid_q;
  logic [IDX_W-1:0]     owner_q;
  logic                 valid_d;
  logic [IDX_W-1:0]     owner_d;

  logic [N_MASTERS-1:0] elig;
  logic [N_MASTERS-1:0] own_hot;
  logic [N_MASTERS-1:0] others;
  logic [N_MASTERS-1:0] cand;
  logic                 own_live;
  logic                 slot_expired;
  logic                 slot_break;
  logic                 hold;
  logic                 pick_found;
  logic [IDX_W-1:0]     pick_idx;
  logic                 park_ok;
  logic [IDX_W-1:0]     park_sel;
  logic                 keep_owner;

  arb_cfg_decode u_dec (
    .cfg_word (cfg_word),
    .cfg      (cfg)
  );

  assign elig     = mst_req & mst_attached;
  assign own_hot  = {{(N_MASTERS-1){1'b0}}, 1'b1} << owner_q;
  assign others   = elig & ~own_hot;
  assign own_live = valid_q && mst_req[owner_q] && mst_attached[owner_q];

  assign slot_break = own_live && slot_expired;
  assign hold       = own_live && mst_burst[owner_q] && !slot_expired;
  assign cand       = slot_break ? others : elig;

  arb_pick #(.N_MASTERS(N_MASTERS)) u_pick (
    .cand     (cand),
    .last_idx (owner_q),
    .use_rr   (cfg.use_rr),
    .found    (pick_found),
    .pick_idx (pick_idx)
  );

  // parking target must exist and be attached
  always_comb begin
    park_ok  = 1'b0;
    park_sel = owner_q;
    for (int i = 0; i < N_MASTERS; i++) begin
      if (int'(cfg.park_idx) == i) begin
        park_ok  = mst_attached[i];
        park_sel = IDX_W'(i);
      end
    end
  end

  always_comb begin
    valid_d = valid_q;
    owner_d = owner_q;
    if (hold || (slot_break && others == '0)) begin
      valid_d = valid_q;
      owner_d = owner_q;
    end else if (pick_found) begin
      valid_d = 1'b1;
      owner_d = pick_idx;
    end else begin
      unique case (cfg.park)
        PARK_LAST: begin
          valid_d = valid_q && mst_attached[owner_q];
        end
        PARK_FIXED: begin
          valid_d = park_ok;
          owner_d = park_ok ? park_sel : owner_q;
        end
        default: begin
          valid_d = 1'b0;
        end
      endcase
    end
  end

  assign keep_owner = valid_d && valid_q && (owner_d == owner_q);

  arb_slot_timer #(.CNT_W(SLOT_W)) u_slot (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (keep_owner && mst_req[owner_q]),
    .limit   (cfg.slot_limit),
    .expired (slot_expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      owner_q <= IDX_W'(N_MASTERS - 1);
    end else begin
      valid_q <= valid_d;
      owner_q <= owner_d;
    end
  end

  for (genvar g = 0; g < N_MASTERS; g++) begin : g_grant
    assign grant[g] = valid_q && (owner_q == IDX_W'(g));
  end

  assign owner_idx   = owner_q;
  assign owner_valid = valid_q;

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R2

  AST_GRANT_ATTACHED: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |-> |(grant & $past(mst_attached))); // R10

  AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_valid && mst_req[owner_idx] && mst_burst[owner_idx] &&
     mst_attached[owner_idx] && !slot_expired)
    |=> (owner_valid && owner_idx == $past(owner_idx))); // R5

  AST_SLOT_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
    (own_live && slot_expired && (others != '0))
    |=> (owner_valid && owner_idx != $past(owner_idx))); // R6

  AST_NO_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.park == PARK_NONE && elig == '0) |=> !owner_valid); // R7

  AST_FIXED_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.park == PARK_FIXED && elig == '0 && park_ok)
    |=> (owner_valid && int'(owner_idx) == int'($past(cfg.park_idx)))); // R9

endmodule

// File: tb/slave_arbiter_tb.sv
module slave_arbiter_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] mst_req = '0;
  logic [N-1:0] mst_burst = '0;
  logic [N-1:0] mst_attached = '1;
  logic [31:0]  cfg_word = '0;
  logic [N-1:0] grant;
  logic [2:0]   owner_idx;
  logic         owner_valid;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slave_arbiter #(.N_MASTERS(N)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .mst_req      (mst_req),
    .mst_burst    (mst_burst),
    .mst_attached (mst_attached),
    .cfg_word     (cfg_word),
    .grant        (grant),
    .owner_idx    (owner_idx),
    .owner_valid  (owner_valid)
  );

  function automatic logic [31:0] mkcfg(logic [7:0] slot, logic [1:0] idle,
                                        logic [2:0] park, logic [1:0] mode);
    return {6'b0, mode, 3'b0, park, idle, 8'b0, slot};
  endfunction

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset(logic [31:0] cfg);
    rst_n = 1'b0;
    mst_req = '0;
    mst_burst = '0;
    mst_attached = '1;
    cfg_word = cfg;
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1'b1;
  endtask

  task automatic chk(string tag, logic ev, int ei);
    logic [N-1:0] exp_g;
    exp_g = ev ? (N'(1) << ei) : '0;
    tests++;
    if (grant !== exp_g || owner_valid !== ev || (ev && owner_idx !== 3'(ei))) begin
      fails++;
      $display("FAIL %s: grant=%b valid=%0b idx=%0d expected grant=%b valid=%0b idx=%0d",
               tag, grant, owner_valid, owner_idx, exp_g, ev, ei);
    end
  endtask

  task automatic t_reset();
    do_reset(mkcfg(8'd0, 2'd0, 3'd0, 2'd0));
    tests++;
    if (grant !== '0 || owner_valid !== 1'b0 || owner_idx !== 3'd7) begin
      fails++;
      $display("FAIL R1: grant=%b valid=%0b idx=%0d expected grant=0 valid=0 idx=7",
               grant, owner_valid, owner_idx);
    end
  endtask

  task automatic t_latency_no_park();
    do_reset(mkcfg(8'd0, 2'd0, 3'd0, 2'd0));
    mst_req[3] = 1'b1;
    chk("R2 no grant in request cycle", 1'b0, 0);
    step();
    chk("R2 grant one cycle later", 1'b1, 3);
    mst_req[3] = 1'b0;
    step();
    chk("R7 idle drops grant", 1'b0, 0);
    cfg_word = mkcfg(8'd0, 2'd3, 3'd0, 2'd0);
    mst_req[6] = 1'b1;
    step();
    chk("R7 grant under reserved idle policy", 1'b1, 6);
    mst_req[6] = 1'b0;
    step();
    chk("R7 reserved idle policy drops grant", 1'b0, 0);
  endtask

  task automatic t_park_last();
    do_reset(mkcfg(8'd0, 2'd1, 3'd0, 2'd0));
    mst_req[5] = 1'b1;
    step();
    chk("R8 first grant", 1'b1, 5);
    mst_req[5] = 1'b0;
    step();
    chk("R8 parked on last owner", 1'b1, 5);
    step();
    chk("R8 still parked", 1'b1, 5);
    mst_req[5] = 1'b1;
    chk("R8 grant present in request cycle", 1'b1, 5);
    mst_req[5] = 1'b0;
  endtask

  task automatic t_park_fixed();
    do_reset(mkcfg(8'd0, 2'd2, 3'd6, 2'd0));
    step();
    chk("R9 idle parks on fixed master", 1'b1, 6);
    cfg_word = mkcfg(8'd0, 2'd2, 3'd2, 2'd0);
    mst_attached[2] = 1'b0;
    step();
    chk("R9 unattached fixed master acts as no parking", 1'b0, 0);
    mst_attached[2] = 1'b1;
    step();
    chk("R9 attached fixed master parks", 1'b1, 2);
  endtask

  task automatic t_unattached();
    do_reset(mkcfg(8'd0, 2'd0, 3'd0, 2'd0));
    mst_attached[1] = 1'b0;
    mst_req[1] = 1'b1;
    step();
    step();
    chk("R10 unattached request ignored", 1'b0, 0);
    mst_req[4] = 1'b1;
    step();
    chk("R10 attached master granted instead", 1'b1, 4);
  endtask

  task automatic t_fixed_prio();
    do_reset(mkcfg(8'd0, 2'd0, 3'd0, 2'd1));
    mst_req = 8'b0110_0100;
    step();
    chk("R3 lowest index wins", 1'b1, 2);
    step();
    chk("R3 lowest index wins again", 1'b1, 2);
    mst_req[2] = 1'b0;
    step();
    chk("R3 next lowest after release", 1'b1, 5);
  endtask

  task automatic t_round_robin(logic [1:0] mode);
    do_reset(mkcfg(8'd0, 2'd0, 3'd0, mode));
    mst_req = 8'b0110_0100;
    step();
    chk("R4 rr first from master 0", 1'b1, 2);
    step();
    chk("R4 rr rotates", 1'b1, 5);
    step();
    chk("R4 rr rotates again", 1'b1, 6);
    step();
    chk("R4 rr wraps", 1'b1, 2);
  endtask

  task automatic t_burst_hold();
    int bad;
    do_reset(mkcfg(8'd0, 2'd0, 3'd0, 2'd0));
    mst_req[1] = 1'b1;
    mst_burst[1] = 1'b1;
    step();
    chk("R5 burst owner granted", 1'b1, 1);
    mst_req[4] = 1'b1;
    mst_burst[4] = 1'b1;
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      step();
      if (grant !== 8'b0000_0010) bad++;
    end
    tests++;
    if (bad != 0) begin
      fails++;
      $display("FAIL R5: %0d cycles with grant moved, expected 0", bad);
    end
    mst_burst[1] = 1'b0;
    step();
    chk("R11 boundary re-arbitrates", 1'b1, 4);
  endtask

  task automatic t_slot_break();
    do_reset(mkcfg(8'd4, 2'd0, 3'd0, 2'd0));
    mst_req[1] = 1'b1;
    mst_burst[1] = 1'b1;
    step();
    chk("R6 owner cycle 1", 1'b1, 1);
    mst_req[3] = 1'b1;
    mst_burst[3] = 1'b1;
    for (int i = 2; i <= 4; i++) begin
      step();
      chk("R6 owner within slot", 1'b1, 1);
    end
    step();
    chk("R6 slot ends, competitor granted", 1'b1, 3);
    repeat (3) step();
    chk("R6 competitor within slot", 1'b1, 3);
    step();
    chk("R6 slot ends, back to first", 1'b1, 1);

    do_reset(mkcfg(8'd2, 2'd0, 3'd0, 2'd0));
    mst_req[1] = 1'b1;
    mst_burst[1] = 1'b1;
    repeat (10) step();
    chk("R6 no competitor keeps owner", 1'b1, 1);

    do_reset(mkcfg(8'd1, 2'd0, 3'd0, 2'd0));
    mst_req = 8'b0000_1010;
    mst_burst = 8'b0000_1010;
    step();
    chk("R6 limit 1 first", 1'b1, 1);
    step();
    chk("R6 limit 1 alternates", 1'b1, 3);
    step();
    chk("R6 limit 1 alternates back", 1'b1, 1);
  endtask

  initial begin
    t_reset();
    t_latency_no_park();
    t_park_last();
    t_park_fixed();
    t_unattached();
    t_fixed_prio();
    t_round_robin(2'd0);
    t_round_robin(2'd3);
    t_burst_hold();
    t_slot_break();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule